// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects reset requests from six places (power-up detection, the external reset pin, a watchdog timeout, an internal halt such as a double bus fault, loss of the clock reference, and test mode). It decides which of them caused the reset and drives three reset lines. One line goes out to the board-level reset pin. One resets the clock generator. One is the master reset for the rest of the chip. Every request passes through a two-stage synchronizer on the system clock before it has any effect.

Power-up, the pin, the watchdog and halt are treated as catastrophic, so they act on the first clock edge after synchronization. Clock loss and test mode are orderly: they wait until the bus reports that no cycle is in flight, so that a write already under way completes first. While such a request waits, an internal bus monitor counts busy cycles. If the bus is still busy when the limit is reached, the monitor pulses an abort to end the hung cycle, and the reset then goes ahead. Once a reset has begun, its lines stay asserted for a fixed number of cycles and are then dropped together. A one-hot cause register keeps the winning source after the reset is released.

Top module: `reset_sequencer`

## Requirements
- R1: Each request input passes through a two-flop synchronizer. If a request is first sampled high at rising edge N, the reset outputs rise on edge N+2 and are visible in the cycle after it, provided the block is idle or a synchronous request is waiting.
- R2: Power-up, pin, watchdog and halt requests start the reset without regard to `bus_busy`.
- R3: A clock-loss or test request starts the reset at the first edge where it is synchronized (or already pending) and `bus_busy` is low. While `bus_busy` stays high, no reset output rises.
- R4: While a synchronous request is pending, the bus monitor counts the cycles in which `bus_busy` is high. On the BMON_LIMIT-th such cycle (default 64), `bmon_abort_o` pulses for one cycle in the same cycle the reset lines rise, and the reset proceeds.
- R5: The lines asserted for each cause are as follows. Power-up, watchdog, halt and clock loss assert all three. The pin asserts clock and master. Test mode asserts external and master. The master line is high whenever either of the other two is high.
- R6: When several requests become valid on the same edge, priority from highest to lowest is power-up, pin, watchdog, halt, clock loss, test.
- R7: The reset lines stay high for exactly HOLD_CYCLES cycles (default 512) and fall together on the same edge.
- R8: `cause_o` is one-hot with bit 0 power-up, bit 1 pin, bit 2 watchdog, bit 3 halt, bit 4 clock loss, bit 5 test. It keeps its value after release and is replaced only when the next reset starts.
- R9: Requests that arrive while the reset lines are held change neither the pulse length nor `cause_o`, and they do not start a new reset afterwards if they are gone before release.
- R10: An asynchronous request that arrives while a synchronous one is waiting on the bus starts the reset at once, and its own cause is recorded.
- R11: After `rst`, all reset lines, `bmon_abort_o` and `cause_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high initialisation |
| por_req | input | 1 | Power-up detected (asynchronous) |
| pin_req | input | 1 | External reset pin asserted (asynchronous) |
| wdog_req | input | 1 | Watchdog timeout (asynchronous) |
| halt_req | input | 1 | Internal halt / double bus fault (asynchronous) |
| clkloss_req | input | 1 | Clock reference lost (synchronous) |
| test_req | input | 1 | Test mode reset (synchronous) |
| bus_busy | input | 1 | A bus cycle is in progress |
| ext_rst_o | output | 1 | Drives the external reset pin |
| clk_rst_o | output | 1 | Resets the clock module |
| mst_rst_o | output | 1 | Master reset for all other logic |
| bmon_abort_o | output | 1 | One-cycle forced termination of a hung bus cycle |
| cause_o | output | 6 | One-hot reset cause register |

## Verification
The hardest situation to reach from the ports is the one where a deferred request is overtaken. A test-mode request must be parked behind a bus that stays busy, and a halt request must then arrive while the bus monitor is still counting. The stimulus holds `bus_busy` high, raises the test request, and waits five cycles before raising halt. It then expects the reset three cycles later with a halt cause and no abort. Separate runs hold the bus busy until the monitor limit expires, or drop it after ten cycles. Those runs pin down the exact cycle of the deferred reset in both cases.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int NSRC = 6;
  localparam int SRC_POR  = 0;
  localparam int SRC_PIN  = 1;
  localparam int SRC_WDG  = 2;
  localparam int SRC_HALT = 3;
  localparam int SRC_CLKL = 4;
  localparam int SRC_TEST = 5;
  localparam logic [NSRC-1:0] ASYNC_SET = 6'b001111;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} seq_state_e;

  typedef struct packed {
    logic ext;
    logic clk;
    logic mst;
  } rst_lines_t;

  function automatic rst_lines_t lines_for(input logic [NSRC-1:0] oh);
    rst_lines_t l;
    l = '{ext: 1'b0, clk: 1'b0, mst: 1'b0};
    if (oh[SRC_POR] | oh[SRC_WDG] | oh[SRC_HALT] | oh[SRC_CLKL])
      l = '{ext: 1'b1, clk: 1'b1, mst: 1'b1};
    else if (oh[SRC_PIN])
      l = '{ext: 1'b0, clk: 1'b1, mst: 1'b1};
    else if (oh[SRC_TEST])
      l = '{ext: 1'b1, clk: 1'b0, mst: 1'b1};
    return l;
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/rstseq_pick.sv
module rstseq_pick #(
  parameter int W = 6
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] oh
);
  // lowest index has the highest priority
  assign oh = req & (~req + W'(1));
endmodule

// File: rtl/rstseq_busmon.sv
module rstseq_busmon #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic busy,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm) cnt <= '0;
    else if (busy)   cnt <= cnt + CW'(1);
  end

  assign expire = arm && busy && (cnt == CW'(LIMIT - 1));

  // R4: the counter never runs past its limit while armed
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    arm |-> (cnt <= CW'(LIMIT - 1)));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 512,
  parameter int BMON_LIMIT  = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            por_req,
  input  logic            pin_req,
  input  logic            wdog_req,
  input  logic            halt_req,
  input  logic            clkloss_req,
  input  logic            test_req,
  input  logic            bus_busy,
  output logic            ext_rst_o,
  output logic            clk_rst_o,
  output logic            mst_rst_o,
  output logic            bmon_abort_o,
  output logic [NSRC-1:0] cause_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [NSRC-1:0] raw, rq, a_rq, s_rq, a_oh, s_oh;
  assign raw  = {test_req, clkloss_req, halt_req, wdog_req, pin_req, por_req};
  assign a_rq = rq & ASYNC_SET;
  assign s_rq = rq & ~ASYNC_SET;

  rstseq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(rq));
  rstseq_pick #(.W(NSRC)) u_pick_a (.req(a_rq), .oh(a_oh));
  rstseq_pick #(.W(NSRC)) u_pick_s (.req(s_rq), .oh(s_oh));

  seq_state_e      st, st_n;
  logic [NSRC-1:0] pend, pend_n, go_oh;
  logic [HW-1:0]   hcnt;
  logic            go, release_n, abort_n, expire;
  rst_lines_t      lines;

  rstseq_busmon #(.LIMIT(BMON_LIMIT)) u_bmon (
    .clk(clk), .rst(rst), .arm(st == ST_WAIT), .busy(bus_busy), .expire(expire));

  always_comb begin
    st_n      = st;
    pend_n    = pend;
    go        = 1'b0;
    go_oh     = '0;
    abort_n   = 1'b0;
    release_n = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (|a_rq) begin
          go = 1'b1; go_oh = a_oh;
        end else if (|s_rq) begin
          if (!bus_busy) begin
            go = 1'b1; go_oh = s_oh;
          end else begin
            st_n = ST_WAIT; pend_n = s_oh;
          end
        end
      end
      ST_WAIT: begin
        if (|a_rq) begin
          go = 1'b1; go_oh = a_oh;
        end else if (!bus_busy) begin
          go = 1'b1; go_oh = pend;
        end else if (expire) begin
          go = 1'b1; go_oh = pend; abort_n = 1'b1;
        end
      end
      ST_HOLD: begin
        if (hcnt == HW'(HOLD_CYCLES - 1)) begin
          release_n = 1'b1; st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (go) begin
      st_n   = ST_HOLD;
      pend_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      pend         <= '0;
      hcnt         <= '0;
      lines        <= '{ext: 1'b0, clk: 1'b0, mst: 1'b0};
      bmon_abort_o <= 1'b0;
      cause_o      <= '0;
    end else begin
      st           <= st_n;
      pend         <= pend_n;
      bmon_abort_o <= abort_n;
      if (go) begin
        hcnt    <= '0;
        cause_o <= go_oh;
        lines   <= lines_for(go_oh);
      end else if (release_n) begin
        lines <= '{ext: 1'b0, clk: 1'b0, mst: 1'b0};
      end else if (st == ST_HOLD) begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  assign ext_rst_o = lines.ext;
  assign clk_rst_o = lines.clk;
  assign mst_rst_o = lines.mst;

  // R5: the master line covers every other asserted line
  a_r5_mst_covers: assert property (@(posedge clk) disable iff (rst)
    (ext_rst_o || clk_rst_o) |-> mst_rst_o);
  // R7: all lines drop on the same edge
  a_r7_release_together: assert property (@(posedge clk) disable iff (rst)
    $fell(mst_rst_o) |-> (!ext_rst_o && !clk_rst_o));
  // R8: the cause register is one-hot or empty
  a_r8_cause_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cause_o));
  // R9: cause cannot move while lines are held
  a_r9_cause_stable: assert property (@(posedge clk) disable iff (rst)
    (mst_rst_o && $past(mst_rst_o)) |-> $stable(cause_o));
  // R4: an abort pulse only accompanies a starting reset
  a_r4_abort_with_reset: assert property (@(posedge clk) disable iff (rst)
    bmon_abort_o |-> (mst_rst_o && !$past(mst_rst_o)));
  // R3: a deferred request stays deferred while the bus is busy
  a_r3_sync_waits: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && bus_busy && !expire && !(|a_rq)) |=> !mst_rst_o);
endmodule

// File: tb/reset_sequencer_test.sv
`timescale 1ns/1ps
module reset_sequencer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] raw = '0;
  logic busy = 1'b0;
  logic ext_o, clk_o, mst_o, abrt_o;
  logic [5:0] cause;

  always #2 clk = ~clk;

  reset_sequencer uut (
    .clk(clk), .rst(rst),
    .por_req(raw[0]), .pin_req(raw[1]), .wdog_req(raw[2]), .halt_req(raw[3]),
    .clkloss_req(raw[4]), .test_req(raw[5]), .bus_busy(busy),
    .ext_rst_o(ext_o), .clk_rst_o(clk_o), .mst_rst_o(mst_o),
    .bmon_abort_o(abrt_o), .cause_o(cause));

  typedef struct {
    logic [5:0] cause;
    logic       ext;
    logic       clkr;
    logic       abrt;
    int         lat;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int cyc = 0, t_start = 0, n_chk = 0, n_bad = 0, width = 0;
  logic in_pulse = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic exp_t mk(input logic [5:0] c, input logic e, input logic k,
                              input logic a, input int l, input string t);
    exp_t x;
    x.cause = c; x.ext = e; x.clkr = k; x.abrt = a; x.lat = l; x.tag = t;
    return x;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mst_o && !in_pulse) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected reset", 1, 0);
        end else begin
          cur = q.pop_front();
          chk(cyc - t_start == cur.lat, {cur.tag, " latency"}, cyc - t_start, cur.lat);
          chk(cause == cur.cause, "R6 cause", int'(cause), int'(cur.cause));
          chk(ext_o == cur.ext, "R5 ext line", int'(ext_o), int'(cur.ext));
          chk(clk_o == cur.clkr, "R5 clk line", int'(clk_o), int'(cur.clkr));
          chk(abrt_o == cur.abrt, "R4 abort", int'(abrt_o), int'(cur.abrt));
        end
        in_pulse = 1'b1;
        width = 1;
      end else if (mst_o) begin
        width++;
      end else if (in_pulse) begin
        in_pulse = 1'b0;
        chk(width == 512, "R7 width", width, 512);
        chk(!ext_o && !clk_o, "R7 together", int'({ext_o, clk_o}), 0);
        chk(cause == cur.cause, "R8 persists", int'(cause), int'(cur.cause));
      end
    end
  end

  task automatic fire(input logic [5:0] s, input exp_t e);
    @(negedge clk);
    t_start = cyc;
    q.push_back(e);
    raw = s;
    repeat (3) @(negedge clk);
    raw = '0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (q.size() != 0 || in_pulse) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({ext_o, clk_o, mst_o, abrt_o} == 4'b0, "R11 lines", int'({ext_o, clk_o, mst_o, abrt_o}), 0);
    chk(cause == 6'b0, "R11 cause", int'(cause), 0);

    // R1 pin: clk+mst
    fire(6'b000010, mk(6'b000010, 1'b0, 1'b1, 1'b0, 3, "R1"));
    wait_done();
    // R6 power-up beats watchdog, all three lines
    fire(6'b000101, mk(6'b000001, 1'b1, 1'b1, 1'b0, 3, "R6"));
    wait_done();
    // R8 replaced by the next cause
    fire(6'b000100, mk(6'b000100, 1'b1, 1'b1, 1'b0, 3, "R8"));
    wait_done();
    // R2 halt ignores a busy bus
    busy = 1'b1;
    fire(6'b001000, mk(6'b001000, 1'b1, 1'b1, 1'b0, 3, "R2"));
    wait_done();
    busy = 1'b0;
    // R3 clock loss with an idle bus
    fire(6'b010000, mk(6'b010000, 1'b1, 1'b1, 1'b0, 3, "R3"));
    wait_done();
    // R3 test waits for the bus to go idle
    busy = 1'b1;
    fire(6'b100000, mk(6'b100000, 1'b1, 1'b0, 1'b0, 11, "R3"));
    repeat (6) @(negedge clk);
    chk(mst_o == 1'b0, "R3 deferred", int'(mst_o), 0);
    @(negedge clk);
    busy = 1'b0;
    wait_done();
    // R4 stuck bus: monitor aborts
    busy = 1'b1;
    fire(6'b100000, mk(6'b100000, 1'b1, 1'b0, 1'b1, 67, "R4"));
    wait_done();
    busy = 1'b0;
    // R10 async overtakes a pending sync request
    busy = 1'b1;
    @(negedge clk);
    raw = 6'b100000;
    repeat (5) @(negedge clk);
    t_start = cyc;
    q.push_back(mk(6'b001000, 1'b1, 1'b1, 1'b0, 3, "R10"));
    raw = 6'b101000;
    repeat (3) @(negedge clk);
    raw = '0;
    wait_done();
    busy = 1'b0;
    // R6 watchdog beats halt, clock loss, test
    fire(6'b111100, mk(6'b000100, 1'b1, 1'b1, 1'b0, 3, "R6"));
    wait_done();
    // R6 clock loss beats test
    fire(6'b110000, mk(6'b010000, 1'b1, 1'b1, 1'b0, 3, "R6"));
    wait_done();
    // R9 request during hold is ignored
    fire(6'b001000, mk(6'b001000, 1'b1, 1'b1, 1'b0, 3, "R9"));
    while (!in_pulse) @(negedge clk);
    repeat (100) @(negedge clk);
    raw = 6'b000010;
    repeat (3) @(negedge clk);
    raw = '0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(mst_o == 1'b0, "R9 no retrigger", int'(mst_o), 0);
    chk(cause == 6'b001000, "R9 cause kept", int'(cause), 8);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule